// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received frames into memory buffers that software owns. Software sets up the buffers as a circular ring of descriptors. Each descriptor is two words: the buffer address, then a control word that gives the buffer size and an interrupt request bit. Software also sets up a parallel ring of two-word status entries. For each frame the block reads the descriptor at the produce index and streams the frame words into that buffer. It then writes the frame's status entry and advances the produce index. Software reads completed entries and hands slots back by moving the consume index.

A small register port holds the descriptor ring base, the status ring base, the descriptor count minus one, and both indices. Memory is reached through one single-port request interface. Read data returns on the cycle after the request. Frames arrive as a stream of 32-bit beats with a last marker. The last beat also carries the count of valid bytes and an error flag from the upstream receive logic. If the ring has no free slot when a frame starts, the block discards the whole frame and pulses an overflow flag.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, every register reads zero, `in_ready_o` is low and no memory request is made.
- R2: The register word addresses are 0 for the descriptor ring base, 1 for the status ring base, 2 for the count minus one, 3 for the produce index and 4 for the consume index. A write to address 3 has no effect.
- R3: For descriptor index i, the block reads the buffer pointer at ring base + 8*i and the control word at ring base + 8*i + 4. Frame beat b is written to pointer + 4*b.
- R4: The status entry for index i sits at status base + 8*i. Bits [10:0] of its first word hold the stored byte length minus one, and its second word is written as zero.
- R5: The buffer size is control bits [10:0] plus one. A beat whose start offset is at or beyond the size is not written, the stored length is capped at the size, and bit 26 of the first status word is set.
- R6: An error flag on the last beat sets bit 23 of the first status word. This bit lies inside the error mask 0x1B800000, and the range bit 26 lies outside it.
- R7: The produce index advances by one only after both status words are written. It wraps from the count minus one back to zero.
- R8: If produce+1 (wrapped) equals the consume index when a frame starts, the frame is accepted and discarded. Nothing is written to memory, the produce index does not change, and `overflow_o` pulses for one cycle on the last beat.
- R9: `irq_o` pulses for one cycle once per completed descriptor whose control bit 31 is set, and stays low otherwise.
- R10: The frame length in bytes is 4*(beats-1) + `in_last_bytes_i` + 1, where `in_last_bytes_i` gives the valid bytes of the last beat minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| in_valid_i | input | 1 | Frame beat valid |
| in_data_i | input | 32 | Frame beat data |
| in_last_i | input | 1 | Last beat of frame |
| in_last_bytes_i | input | 2 | Valid bytes in last beat minus one |
| in_err_i | input | 1 | Frame error, sampled on last beat |
| in_ready_o | output | 1 | Beat accepted when high with valid |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after a read request |
| irq_o | output | 1 | Completion interrupt pulse |
| overflow_o | output | 1 | Dropped-frame pulse |

## Verification
The bench fills the ring without consuming anything, so the fourth frame meets a full ring. A design that checked fullness after advancing, or not at all, would overwrite the oldest unread slot, and the bench's memory write count would catch it. Frames one byte longer than their buffer and exactly as long as their buffer test the truncation edge. An off-by-one there would either spill a word into guard memory filled with a known pattern, or wrongly set or miss the range bit. Random frame lengths, error flags and consume moves drive the produce index through several wraps. A wrong wrap shows up as a status entry written to the wrong slot, or as a produce index read back out of range.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned LEN_W     = 11;
  localparam int unsigned ERR_BIT   = 23;
  localparam int unsigned RANGE_BIT = 26;
  localparam int unsigned IRQ_BIT   = 31;

  localparam logic [2:0] RA_RING = 3'd0;
  localparam logic [2:0] RA_STAT = 3'd1;
  localparam logic [2:0] RA_CNT  = 3'd2;
  localparam logic [2:0] RA_PROD = 3'd3;
  localparam logic [2:0] RA_CONS = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_PTR, S_RD_CTL, S_WAIT, S_DATA, S_ST0, S_ST1, S_ADV, S_DROP
  } seq_state_e;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
  import rxr_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             adv_i,
  output logic [DW-1:0]    ring_base_o,
  output logic [DW-1:0]    stat_base_o,
  output logic [IDX_W-1:0] prod_o,
  output logic [IDX_W-1:0] cons_o,
  output logic [IDX_W-1:0] prod_next_o
);
  localparam int unsigned PAD_W = DW - IDX_W;

  logic [DW-1:0]    ring_q, stat_q;
  logic [IDX_W-1:0] cnt_q, prod_q, cons_q;

  assign prod_next_o = (prod_q == cnt_q) ? '0 : prod_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q <= '0;
      stat_q <= '0;
      cnt_q  <= '0;
      prod_q <= '0;
      cons_q <= '0;
    end else begin
      if (reg_we_i) begin
        case (reg_addr_i)
          RA_RING: ring_q <= reg_wdata_i;
          RA_STAT: stat_q <= reg_wdata_i;
          RA_CNT:  cnt_q  <= reg_wdata_i[IDX_W-1:0];
          RA_CONS: cons_q <= reg_wdata_i[IDX_W-1:0];
          default: ;
        endcase
      end
      if (adv_i) prod_q <= prod_next_o;
    end
  end

  always_comb begin
    case (reg_addr_i)
      RA_RING: reg_rdata_o = ring_q;
      RA_STAT: reg_rdata_o = stat_q;
      RA_CNT:  reg_rdata_o = {{PAD_W{1'b0}}, cnt_q};
      RA_PROD: reg_rdata_o = {{PAD_W{1'b0}}, prod_q};
      RA_CONS: reg_rdata_o = {{PAD_W{1'b0}}, cons_q};
      default: reg_rdata_o = '0;
    endcase
  end

  assign ring_base_o = ring_q;
  assign stat_base_o = stat_q;
  assign prod_o      = prod_q;
  assign cons_o      = cons_q;

  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && prod_q == cnt_q) |=> (prod_q == '0));

  a_r2_prod_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == RA_PROD && !adv_i) |=> $stable(prod_q));
endmodule

// File: rtl/rxr_status_fmt.sv
module rxr_status_fmt
  import rxr_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned SZ_W   = 12,
  parameter int unsigned LEN_CW = 16
) (
  input  logic [LEN_CW-1:0] total_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic              err_i,
  output logic [DW-1:0]     word_o,
  output logic              trunc_o
);
  logic [LEN_CW-1:0] stored;
  logic [LEN_W-1:0]  stored_m1;

  assign trunc_o   = total_i > LEN_CW'(size_i);
  assign stored    = trunc_o ? LEN_CW'(size_i) : total_i;
  assign stored_m1 = LEN_W'(stored - 1'b1);

  always_comb begin
    word_o            = '0;
    word_o[LEN_W-1:0] = stored_m1;
    word_o[ERR_BIT]   = err_i;
    word_o[RANGE_BIT] = trunc_o;
  end
endmodule

// File: rtl/rxr_seq.sv
module rxr_seq
  import rxr_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned SZ_W   = 12,
  parameter int unsigned LEN_CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DW-1:0]     in_data_i,
  input  logic              in_last_i,
  input  logic [1:0]        in_last_bytes_i,
  input  logic              in_err_i,
  output logic              in_ready_o,
  input  logic [DW-1:0]     ring_base_i,
  input  logic [DW-1:0]     stat_base_i,
  input  logic [IDX_W-1:0]  prod_i,
  input  logic              full_i,
  output logic              adv_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic [DW-1:0]     stat_word_i,
  output logic [LEN_CW-1:0] total_o,
  output logic [SZ_W-1:0]   size_o,
  output logic              err_o,
  output logic              irq_o,
  output logic              overflow_o
);
  localparam int unsigned ENTRY_SH = 3;
  localparam int unsigned BEAT_B   = DW / 8;

  seq_state_e        state_q;
  logic [DW-1:0]     ptr_q;
  logic [LEN_W-1:0]  size_m1_q;
  logic              irq_req_q;
  logic [LEN_CW-1:0] off_q, total_q;
  logic              err_q;

  logic [DW-1:0] desc_addr, stat_addr;
  logic [SZ_W-1:0] size;
  logic in_range;

  assign desc_addr = ring_base_i + (DW'(prod_i) << ENTRY_SH);
  assign stat_addr = stat_base_i + (DW'(prod_i) << ENTRY_SH);
  assign size      = {1'b0, size_m1_q} + 1'b1;
  assign in_range  = off_q < LEN_CW'(size);

  assign size_o  = size;
  assign total_o = total_q;
  assign err_o   = err_q;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    adv_o       = 1'b0;
    irq_o       = 1'b0;
    case (state_q)
      S_RD_PTR: begin mem_req_o = 1'b1; mem_addr_o = desc_addr; end
      S_RD_CTL: begin mem_req_o = 1'b1; mem_addr_o = desc_addr + DW'(BEAT_B); end
      S_DATA: begin
        mem_req_o   = in_valid_i && in_range;
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr_q + DW'(off_q);
        mem_wdata_o = in_data_i;
      end
      S_ST0: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = stat_addr; mem_wdata_o = stat_word_i;
      end
      S_ST1: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = stat_addr + DW'(BEAT_B);
      end
      S_ADV: begin adv_o = 1'b1; irq_o = irq_req_q; end
      default: ;
    endcase
  end

  assign in_ready_o = (state_q == S_DATA) || (state_q == S_DROP);
  assign overflow_o = (state_q == S_DROP) && in_valid_i && in_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      ptr_q     <= '0;
      size_m1_q <= '0;
      irq_req_q <= 1'b0;
      off_q     <= '0;
      total_q   <= '0;
      err_q     <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (in_valid_i) begin
          off_q   <= '0;
          state_q <= full_i ? S_DROP : S_RD_PTR;
        end
        S_RD_PTR: state_q <= S_RD_CTL;
        S_RD_CTL: begin ptr_q <= mem_rdata_i; state_q <= S_WAIT; end
        S_WAIT: begin
          size_m1_q <= mem_rdata_i[LEN_W-1:0];
          irq_req_q <= mem_rdata_i[IRQ_BIT];
          state_q   <= S_DATA;
        end
        S_DATA: if (in_valid_i) begin
          off_q <= off_q + LEN_CW'(BEAT_B);
          if (in_last_i) begin
            total_q <= off_q + LEN_CW'(in_last_bytes_i) + 1'b1;
            err_q   <= in_err_i;
            state_q <= S_ST0;
          end
        end
        S_ST0:  state_q <= S_ST1;
        S_ST1:  state_q <= S_ADV;
        S_ADV:  state_q <= S_IDLE;
        S_DROP: if (in_valid_i && in_last_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r5_len_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ST0) |-> (SZ_W'(stat_word_i[LEN_W-1:0]) < size));

  a_r8_drop_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DROP) |-> !mem_req_o);

  a_r9_irq_after_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(state_q == S_ST1));

  a_r7_single_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |=> !adv_o);
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned LEN_CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_last_i,
  input  logic [1:0]    in_last_bytes_i,
  input  logic          in_err_i,
  output logic          in_ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          irq_o,
  output logic          overflow_o
);
  localparam int unsigned SZ_W = LEN_W + 1;

  logic [DW-1:0]     ring_base, stat_base, stat_word;
  logic [IDX_W-1:0]  prod, cons, prod_next;
  logic              adv, full, trunc, err;
  logic [LEN_CW-1:0] total;
  logic [SZ_W-1:0]   size;

  assign full = (prod_next == cons);

  rxr_regs #(.DW(DW), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .adv_i(adv), .ring_base_o(ring_base), .stat_base_o(stat_base),
    .prod_o(prod), .cons_o(cons), .prod_next_o(prod_next)
  );

  rxr_status_fmt #(.DW(DW), .SZ_W(SZ_W), .LEN_CW(LEN_CW)) u_fmt (
    .total_i(total), .size_i(size), .err_i(err),
    .word_o(stat_word), .trunc_o(trunc)
  );

  rxr_seq #(.DW(DW), .IDX_W(IDX_W), .SZ_W(SZ_W), .LEN_CW(LEN_CW)) u_seq (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .in_last_i, .in_last_bytes_i,
    .in_err_i, .in_ready_o, .ring_base_i(ring_base), .stat_base_i(stat_base),
    .prod_i(prod), .full_i(full), .adv_o(adv), .mem_req_o, .mem_we_o,
    .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .stat_word_i(stat_word),
    .total_o(total), .size_o(size), .err_o(err), .irq_o, .overflow_o
  );

  a_r6_range_bit_tracks_trunc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_wdata_o == stat_word && adv == 1'b0 && !in_ready_o && trunc)
      |-> mem_wdata_o[RANGE_BIT]);
endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;
  localparam int RING = 32'h100, STAT = 32'h200, BUF = 32'h400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0; logic [2:0] reg_addr = 0; logic [31:0] reg_wdata = 0, reg_rdata;
  logic in_valid = 0, in_last = 0, in_err = 0, in_ready;
  logic [31:0] in_data = 0; logic [1:0] in_lb = 0;
  logic mem_req, mem_we; logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic irq, ovf;

  always #10 clk = ~clk;

  rx_ring_writer u_rx_ring_writer (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .in_valid_i(in_valid),
    .in_data_i(in_data), .in_last_i(in_last), .in_last_bytes_i(in_lb),
    .in_err_i(in_err), .in_ready_o(in_ready), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .irq_o(irq), .overflow_o(ovf)
  );

  logic [31:0] mem [0:1023];
  logic tb_we = 0; logic [9:0] tb_idx = 0; logic [31:0] tb_dat = 0;
  int wr_cnt, irq_cnt = 0, ovf_cnt = 0, checks = 0, fails = 0;
  int prod_m = 0, cons_m = 0;
  int sizes [4] = '{64, 32, 16, 48};
  bit irqb [4] = '{1'b0, 1'b1, 1'b0, 1'b1};

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= SENT;
      wr_cnt <= 0; mem_rdata <= '0;
    end else begin
      if (tb_we) mem[tb_idx] <= tb_dat;
      if (mem_req && mem_we) begin mem[mem_addr[11:2]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
      if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (ovf) ovf_cnt++;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic mem_put(int idx, logic [31:0] d);
    @(negedge clk); tb_we = 1; tb_idx = 10'(idx); tb_dat = d;
    @(negedge clk); tb_we = 0;
  endtask

  function automatic logic [31:0] beat_word(int fid, int b);
    return {8'(fid), 8'hA5, 16'(b)};
  endfunction

  function automatic logic [31:0] exp_w0(int n, int sz, bit err);
    logic [31:0] w = '0;
    int st = (n > sz) ? sz : n;
    w[10:0] = 11'(st - 1);
    w[23] = err;
    w[26] = (n > sz);
    return w;
  endfunction

  function automatic int nxt(int i);
    return (i == 3) ? 0 : i + 1;
  endfunction

  task automatic send_frame(int fid, int n, bit err);
    int beats = (n + 3) / 4;
    logic r;
    for (int b = 0; b < beats; b++) begin
      @(negedge clk);
      in_valid = 1; in_data = beat_word(fid, b);
      in_last = (b == beats - 1);
      in_lb = in_last ? 2'((n - 1) % 4) : 2'd0;
      in_err = in_last ? err : 1'b0;
      forever begin
        r = in_ready;
        @(posedge clk);
        if (r) break;
        @(negedge clk);
      end
    end
    @(negedge clk); in_valid = 0; in_last = 0; in_err = 0;
  endtask

  task automatic run_frame(int fid, int n, bit err);
    bit full = (nxt(prod_m) == cons_m);
    int i0 = irq_cnt, o0 = ovf_cnt, w0 = wr_cnt, d = prod_m, sz = sizes[prod_m];
    int beats = (n + 3) / 4;
    logic [31:0] v;
    string tag;
    bit bad = 0;
    send_frame(fid, n, err);
    repeat (8) @(negedge clk);
    if (full) begin
      chk("R8", "writes during dropped frame", 32'(wr_cnt - w0), 0);
      chk("R8", "overflow pulses", 32'(ovf_cnt - o0), 1);
      reg_rd(3'd3, v); chk("R8", "produce after drop", v, 32'(prod_m));
    end else begin
      tag = (n > sz) ? "R5" : (err ? "R6" : "R10");
      chk(tag, "status word0 (R4)", mem[STAT/4 + 2*d], exp_w0(n, sz, err));
      chk("R4", "status word1", mem[STAT/4 + 2*d + 1], 0);
      for (int b = 0; b < 16; b++) begin
        v = mem[BUF/4 + 16*d + b];
        if (4*b >= sz && v !== SENT) bad = 1;
        if (4*b < sz && b < beats && v !== beat_word(fid, b)) bad = 1;
      end
      chk("R3", "buffer contents", 32'(bad), 0);
      prod_m = nxt(prod_m);
      reg_rd(3'd3, v); chk("R7", "produce index", v, 32'(prod_m));
      chk("R9", "irq pulses", 32'(irq_cnt - i0), 32'(irqb[d]));
      chk("R8", "no overflow on free slot", 32'(ovf_cnt - o0), 0);
    end
  endtask

  task automatic consume();
    cons_m = nxt(cons_m);
    reg_wr(3'd4, 32'(cons_m));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (5) @(posedge clk);
    // R1: reset state
    #1;
    chk("R1", "in_ready", 32'(in_ready), 0);
    chk("R1", "mem_req", 32'(mem_req), 0);
    for (int a = 0; a < 5; a++) begin
      reg_rd(3'(a), v); chk("R1", "register after reset", v, 0);
    end
    rst_n = 1;
    for (int i = 0; i < 4; i++) begin
      mem_put(RING/4 + 2*i, BUF + 64*i);
      mem_put(RING/4 + 2*i + 1, {irqb[i], 20'd0, 11'(sizes[i] - 1)});
    end
    reg_wr(3'd0, RING); reg_wr(3'd1, STAT); reg_wr(3'd2, 3);
    reg_rd(3'd0, v); chk("R2", "ring base readback", v, RING);
    reg_rd(3'd1, v); chk("R2", "status base readback", v, STAT);
    reg_rd(3'd2, v); chk("R2", "count readback", v, 3);
    reg_wr(3'd3, 2);
    reg_rd(3'd3, v); chk("R2", "produce write ignored", v, 0);

    run_frame(1, 64, 0);   // exactly fills buffer, no range bit
    run_frame(2, 33, 0);   // one byte over 32-byte buffer
    run_frame(3, 10, 1);   // error flag, partial last beat
    run_frame(4, 20, 0);   // ring full: dropped
    consume(); consume();
    run_frame(5, 48, 0);   // fills slot 3 exactly, then wrap
    run_frame(6, 1, 0);    // single byte into slot 0
    reg_rd(3'd3, v); chk("R7", "wrapped produce", v, 1);

    for (int k = 0; k < 24; k++) begin
      if (prod_m != cons_m && ($urandom % 3) != 0) consume();
      run_frame(10 + k, 1 + int'($urandom % 80), ($urandom % 4) == 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule